// File: doc/BRIEF.md
# Bi-phase Infrared Remote Frame Decoder

This block sits behind a demodulating infrared receiver and turns one bi-phase (Manchester) remote-control frame into a 12-bit word. A frame lasts fourteen bit times of about 1.78 ms each. It carries two start bits, a toggle bit, a 5-bit address and a 6-bit command. A one-cycle tick enable at 32.768 kHz paces all timing, so the system clock may run at any rate above it. The receiver line idles high, and a logical one appears on the line as high-then-low.

The decoder is idle until it sees a falling line edge. From then on it re-times itself from every edge it accepts. It samples the line 44 ticks after that edge and shifts the sampled level in as the next bit, most significant first. It then waits for the next edge in either direction. If no edge comes within 29 ticks of the sample point, it drops the partial frame and goes back to idle. A frame ends at the fourteenth sample point. The decoder then pulses a valid strobe and holds the word. It also outputs the 6-bit command field and a flag that shows whether that command equals a match code supplied at an input port. The decoder then re-arms at once for the next frame.

Top module: `ir_biphase_rx`

## Requirements
- R1: After a synchronous active-high reset, `frameWord`, `cmdCode`, `cmdMatch` and `frameValid` are all zero and the decoder is idle.
- R2: While idle, only a falling edge of the synchronised line starts a frame. A rising edge in idle is ignored. A lone short low pulse never produces a frame.
- R3: Each sampled bit is the line level 44 ticks after the last accepted edge. Edges seen during that 44-tick wait are ignored.
- R4: The valid pulse follows the fourteenth sample point. The final accepted edge is seen on the tick after the line changes, so valid is high on tick 45 counted from that line change.
- R5: If no edge arrives on any of the 29 ticks that follow a sample point, the partial frame is discarded. No valid pulse is produced and the held outputs keep their previous values.
- R6: An edge on the 29th tick after a sample point is still accepted, and the frame continues to decode correctly.
- R7: The thirteen sampled bits are shifted in most significant first, and only the low 12 are kept. The result is `frameWord[11]` = toggle, `frameWord[10:6]` = address bits 4..0, `frameWord[5:0]` = command bits 5..0.
- R8: `cmdCode` equals `frameWord[5:0]`. `cmdMatch` is set at each completion when the command equals `matchCode`, and cleared otherwise. Both hold until the next completion.
- R9: After a completed frame or an aborted one, the decoder re-arms immediately. A following frame decodes correctly.
- R10: `frameValid` is high for exactly one clock cycle per completed frame.
- R11: A reset asserted in the middle of a frame returns the decoder to idle. The next full frame then decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle timing tick at 32.768 kHz |
| irIn | input | 1 | Demodulated receiver line, idle high, asynchronous |
| matchCode | input | 6 | Command value that sets `cmdMatch` |
| frameWord | output | 12 | Last decoded word: toggle, address, command |
| frameValid | output | 1 | One-cycle strobe on frame completion |
| cmdCode | output | 6 | Command field of `frameWord` |
| cmdMatch | output | 1 | Last command equalled `matchCode` |

## Verification
The bench sends whole frames built from all-ones, all-zeros, alternating and mixed words. These show whether the bit order and the 12-bit truncation are right, and whether equal-neighbour bits, whose boundary edges must be ignored, are handled. It changes the match code between frames to tell a fixed compare from a programmable one. One mid-bit edge is delayed to land exactly on the last accepted tick, and then one tick later. This separates an off-by-one timeout from a correct one. A lone glitch, a rising edge in idle and a reset mid-frame each check that nothing spurious appears and that the next frame still decodes.

// File: rtl/ir_biphase_pkg.sv
package ir_biphase_pkg;

  // Receiver phase: waiting for a frame, waiting for a sample point,
  // or watching for the mid-bit edge that re-times the next bit.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_WATCH  = 2'd2
  } rxState_t;

  // Strobes from control to datapath, each at most one cycle wide.
  typedef struct packed {
    logic arm;     // load the sample counter and clear the shift register
    logic shift;   // take the line level as the next bit
    logic finish;  // final sample point: publish the word
  } rxCtl_t;

endpackage

// File: rtl/ir_biphase_edge.sv
module ir_biphase_edge (
  input  logic clk,
  input  logic rst,
  input  logic tickEn,
  input  logic irIn,
  output logic level,
  output logic riseEdge,
  output logic fallEdge
);

  logic syncA;
  logic syncB;
  logic prevLevel;

  // Two-flop synchroniser, clocked every cycle; resets to the idle-high level.
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= irIn;
      syncB <= syncA;
    end
  end

  // Reference level is refreshed only on ticks, so edges are seen per tick.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevLevel <= 1'b1;
    end else if (tickEn) begin
      prevLevel <= syncB;
    end
  end

  assign level    = syncB;
  assign riseEdge = tickEn &  syncB & ~prevLevel;
  assign fallEdge = tickEn & ~syncB &  prevLevel;

endmodule

// File: rtl/ir_biphase_ctrl.sv
module ir_biphase_ctrl
  import ir_biphase_pkg::*;
#(
  parameter int SAMPLE_TICKS  = 44,
  parameter int TIMEOUT_TICKS = 29
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tickEn,
  input  logic   riseEdge,
  input  logic   fallEdge,
  input  logic   lastSample,
  output rxCtl_t ctl
);

  localparam int MAX_TICKS = (SAMPLE_TICKS > TIMEOUT_TICKS) ? SAMPLE_TICKS : TIMEOUT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST  = CNT_W'(SAMPLE_TICKS - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic             anyEdge;
  logic             samplePoint;

  assign anyEdge     = riseEdge | fallEdge;
  assign samplePoint = (state == ST_SAMPLE) && tickEn && (tickCnt == SAMPLE_LAST);

  // One tick counter serves both waits: it restarts at every accepted edge
  // and at every sample point.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (fallEdge) begin
            state <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (tickEn) begin
            if (tickCnt == SAMPLE_LAST) begin
              tickCnt <= '0;
              state   <= lastSample ? ST_IDLE : ST_WATCH;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_WATCH: begin
          if (tickEn) begin
            if (anyEdge) begin
              tickCnt <= '0;
              state   <= ST_SAMPLE;
            end else if (tickCnt == TIMEOUT_LAST) begin
              tickCnt <= '0;
              state   <= ST_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: begin
          tickCnt <= '0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.arm    = (state == ST_IDLE) && fallEdge;
    ctl.shift  = samplePoint && !lastSample;
    ctl.finish = samplePoint &&  lastSample;
  end

  // R2: leaving idle needs a falling edge on the previous cycle.
  a_r2_arm_on_fall: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAMPLE && $past(state) == ST_IDLE) |-> $past(fallEdge));

  // R3: the wait to a sample point never runs past its length.
  a_r3_sample_window: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAMPLE) |-> (tickCnt <= SAMPLE_LAST));

  // R5: the edge watch never runs past the timeout window.
  a_r5_watch_window: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WATCH) |-> (tickCnt <= TIMEOUT_LAST));

  // R9: completion returns straight to idle, ready for the next frame.
  a_r9_idle_after_finish: assert property (@(posedge clk) disable iff (rst)
    ctl.finish |=> (state == ST_IDLE));

endmodule

// File: rtl/ir_biphase_dp.sv
module ir_biphase_dp
  import ir_biphase_pkg::*;
#(
  parameter int FRAME_SAMPLES = 14,
  parameter int WORD_W        = 12,
  parameter int CMD_W         = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  rxCtl_t            ctl,
  input  logic              level,
  input  logic [CMD_W-1:0]  matchCode,
  output logic              lastSample,
  output logic [WORD_W-1:0] frameWord,
  output logic              frameValid,
  output logic              cmdMatch
);

  localparam int BIT_CNT_W = $clog2(FRAME_SAMPLES + 1);
  localparam int SHIFT_W   = FRAME_SAMPLES - 1;
  localparam logic [BIT_CNT_W-1:0] SAMPLES_INIT = BIT_CNT_W'(FRAME_SAMPLES);

  logic [BIT_CNT_W-1:0] bitsLeft;
  logic [SHIFT_W-1:0]   shiftReg;

  assign lastSample = (bitsLeft == BIT_CNT_W'(1));

  // Sample counter and shift register for the frame being received.
  always_ff @(posedge clk) begin
    if (rst) begin
      bitsLeft <= '0;
      shiftReg <= '0;
    end else if (ctl.arm) begin
      bitsLeft <= SAMPLES_INIT;
      shiftReg <= '0;
    end else if (ctl.shift) begin
      bitsLeft <= bitsLeft - 1'b1;
      shiftReg <= {shiftReg[SHIFT_W-2:0], level};
    end else if (ctl.finish) begin
      bitsLeft <= '0;
    end
  end

  // Published result, held until the next completed frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      frameWord  <= '0;
      frameValid <= 1'b0;
      cmdMatch   <= 1'b0;
    end else begin
      frameValid <= ctl.finish;
      if (ctl.finish) begin
        frameWord <= shiftReg[WORD_W-1:0];
        cmdMatch  <= (shiftReg[CMD_W-1:0] == matchCode);
      end
    end
  end

  // R7: the sample counter never exceeds its load value.
  a_r7_bits_bounded: assert property (@(posedge clk) disable iff (rst)
    bitsLeft <= SAMPLES_INIT);

  // R4: a valid pulse follows only the last sample point of a frame.
  a_r4_valid_after_last: assert property (@(posedge clk) disable iff (rst)
    frameValid |-> $past(lastSample));

  // R10: the valid strobe lasts a single cycle.
  a_r10_valid_single: assert property (@(posedge clk) disable iff (rst)
    frameValid |=> !frameValid);

endmodule

// File: rtl/ir_biphase_rx.sv
module ir_biphase_rx
  import ir_biphase_pkg::*;
#(
  parameter int SAMPLE_TICKS  = 44,
  parameter int TIMEOUT_TICKS = 29,
  parameter int FRAME_SAMPLES = 14,
  parameter int WORD_W        = 12,
  parameter int CMD_W         = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              irIn,
  input  logic [CMD_W-1:0]  matchCode,
  output logic [WORD_W-1:0] frameWord,
  output logic              frameValid,
  output logic [CMD_W-1:0]  cmdCode,
  output logic              cmdMatch
);

  logic   level;
  logic   riseEdge;
  logic   fallEdge;
  logic   lastSample;
  rxCtl_t ctl;

  ir_biphase_edge uEdge (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .irIn     (irIn),
    .level    (level),
    .riseEdge (riseEdge),
    .fallEdge (fallEdge)
  );

  ir_biphase_ctrl #(
    .SAMPLE_TICKS  (SAMPLE_TICKS),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .tickEn     (tickEn),
    .riseEdge   (riseEdge),
    .fallEdge   (fallEdge),
    .lastSample (lastSample),
    .ctl        (ctl)
  );

  ir_biphase_dp #(
    .FRAME_SAMPLES (FRAME_SAMPLES),
    .WORD_W        (WORD_W),
    .CMD_W         (CMD_W)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .level      (level),
    .matchCode  (matchCode),
    .lastSample (lastSample),
    .frameWord  (frameWord),
    .frameValid (frameValid),
    .cmdMatch   (cmdMatch)
  );

  assign cmdCode = frameWord[CMD_W-1:0];

  // R8: at completion the flag agrees with the code that was presented.
  a_r8_match_flag: assert property (@(posedge clk) disable iff (rst)
    frameValid |-> (cmdMatch == (cmdCode == $past(matchCode))));

endmodule

// File: tb/sim_ir_biphase_rx.sv
module sim_ir_biphase_rx;

  logic        clk = 1'b0;
  logic        rst;
  logic        irIn;
  logic [5:0]  matchCode;
  logic [11:0] frameWord;
  logic        frameValid;
  logic [5:0]  cmdCode;
  logic        cmdMatch;
  logic [1:0]  div = 2'd0;
  logic        tickEn;
  int          tickNow = 0;
  int          nChecks = 0;
  int          nFails  = 0;
  logic        lastValid = 1'b0;
  logic [11:0] lastGood = 12'h000;

  typedef struct {
    logic [11:0] word;
    logic        match;
    int          mark;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  // Tick enable: one cycle in four.
  always @(posedge clk) div <= div + 2'd1;
  assign tickEn = (div == 2'd0);
  always @(posedge clk) if (tickEn) tickNow <= tickNow + 1;

  ir_biphase_rx u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn), .irIn(irIn), .matchCode(matchCode),
    .frameWord(frameWord), .frameValid(frameValid), .cmdCode(cmdCode), .cmdMatch(cmdMatch)
  );

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // Monitor: compare each completed frame against the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (lastValid) chk(!frameValid, "R10", "valid longer than one cycle", frameValid, 0);
      if (frameValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R5", "unexpected frame", frameWord, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(frameWord == e.word, "R7", "frame word", frameWord, e.word);
          chk(cmdCode == e.word[5:0], "R8", "command field", cmdCode, e.word[5:0]);
          chk(cmdMatch == e.match, "R8", "match flag", cmdMatch, e.match);
          chk(tickNow == e.mark + 45, "R4", "valid tick", tickNow - e.mark, 45);
          lastGood = e.word;
        end
      end
    end
    lastValid <= frameValid;
  end

  // Drive a level, then wait n ticks; returns on the negedge after the n-th tick.
  task automatic hold(input logic lvl, input int n);
    int tgt;
    irIn = lvl;
    tgt = tickNow + n;
    while (tickNow < tgt) @(negedge clk);
  endtask

  // Send one frame: S1, S2, then the 12-bit word, one-as-high-then-low.
  // stretchIdx (1..14) lengthens that bit's first half by stretchAmt ticks;
  // abortAt stops driving after that stretched half.
  task automatic sendFrame(input logic [11:0] w, input int stretchIdx,
                           input int stretchAmt, input bit abortAt);
    logic [13:0] b;
    b = {2'b11, w};
    @(negedge clk);
    for (int i = 1; i <= 14; i++) begin
      logic bitv;
      bitv = b[14 - i];
      hold(bitv, 29 + ((i == stretchIdx) ? stretchAmt : 0));
      if (abortAt && i == stretchIdx) begin
        hold(1'b1, 150);
        return;
      end
      if (i == 14) begin
        exp_t e;
        e.word  = w;
        e.match = (w[5:0] == matchCode);
        e.mark  = tickNow;
        expQ.push_back(e);
      end
      hold(~bitv, 29);
    end
    hold(1'b1, 100);
  endtask

  task automatic sendPartial(input logic [11:0] w, input int nBits);
    logic [13:0] b;
    b = {2'b11, w};
    @(negedge clk);
    for (int i = 1; i <= nBits; i++) begin
      hold(b[14 - i], 29);
      hold(~b[14 - i], 29);
    end
    hold(1'b1, 2);
  endtask

  initial begin
    rst = 1'b1;
    irIn = 1'b1;
    matchCode = 6'd32;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(frameWord == 12'h000, "R1", "reset word", frameWord, 0);
    chk(cmdCode == 6'h00, "R1", "reset command", cmdCode, 0);
    chk(cmdMatch == 1'b0, "R1", "reset match", cmdMatch, 0);
    chk(frameValid == 1'b0, "R1", "reset valid", frameValid, 0);
    rst = 1'b0;
    hold(1'b1, 40);

    // R3 R7 R8: main decoding under several patterns.
    sendFrame(12'h160, 0, 0, 1'b0);   // command 32 matches
    sendFrame(12'hFFF, 0, 0, 1'b0);
    sendFrame(12'h000, 0, 0, 1'b0);
    sendFrame(12'hAAA, 0, 0, 1'b0);
    sendFrame(12'h555, 0, 0, 1'b0);   // R9 back-to-back frames
    matchCode = 6'h15;
    sendFrame(12'h255, 0, 0, 1'b0);   // R8 programmable code matches
    sendFrame(12'h260, 0, 0, 1'b0);   // R8 old code no longer matches

    // R6: mid-bit edge lands on the 29th tick after the sample.
    sendFrame(12'h3C5, 6, 15, 1'b0);

    // R5: edge one tick too late on a zero bit; frame must vanish.
    sendFrame(12'h000, 5, 16, 1'b1);
    chk(frameWord == lastGood, "R5", "word kept after timeout", frameWord, lastGood);

    // R2 R5: lone glitch arms then times out; the rising edge after it is ignored.
    @(negedge clk);
    hold(1'b0, 5);
    hold(1'b1, 150);
    chk(frameWord == lastGood, "R2", "word kept after glitch", frameWord, lastGood);

    // R9: decoder re-armed after aborts.
    matchCode = 6'd32;
    sendFrame(12'h9A0, 0, 0, 1'b0);

    // R11: reset in the middle of a frame.
    sendPartial(12'hFFF, 5);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(frameWord == 12'h000, "R11", "word cleared by reset", frameWord, 0);
    chk(cmdMatch == 1'b0, "R11", "match cleared by reset", cmdMatch, 0);
    hold(1'b1, 150);
    sendFrame(12'h2B7, 0, 0, 1'b0);

    hold(1'b1, 200);
    chk(expQ.size() == 0, "R4", "frames still missing", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (R9) actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule